// File: doc/BRIEF.md
# Audio Sample Fetch and DAC Clock Generator

This block feeds a stereo audio DAC from system memory. Software places a start address and a transfer length in two registers. Each length write queues one transfer, and the queue holds up to two transfers. When the enable bit is set, the block reads the queued regions one 64-bit beat at a time over a request/acknowledge memory port. It turns each beat into two stereo samples of 16 bits per channel.

Two programmable dividers run on the block clock, which stands in for the video clock. The first divider makes a sample strobe, which presents the next sample on the output. The second divider makes a square serial bit clock. A status word shows whether the queue is full and whether a transfer is in progress. An interrupt fires when a full queue frees a slot, so that software can refill it.

Registers are written through `reg_sel`:
- 0 selects the start address.
- 1 selects the length.
- 2 selects the control register.
- 3 selects the status-clear action.
- 4 selects the sample period.
- 5 selects the bit-clock half period.

Top module: `audio_dma_dac`

## Requirements
- R1: An address write keeps bits [23:3] of the data and forces bits [2:0] to zero. The beats of a transfer are fetched from the stored address upward in steps of 8.
- R2: A length write (select 1) queues the current address together with a beat count taken from data bits [17:3]. Bits [2:0] are ignored. A beat count of zero queues nothing.
- R3: The queue holds two transfers. With two entries, `reg_status` bit 31 and bit 0 both read 1. A length write while the queue is full is dropped and fetches nothing.
- R4: `mem_req` is raised only while control bit 0 (select 2) is 1 and a transfer is queued.
- R5: Status bit 30 (busy) is 1 whenever `mem_req` is high. After the last beat of the final queued transfer it returns to 0. A second queued transfer is fetched right after the first with no software action.
- R6: `aud_irq` sets in the cycle the full flag falls from 1 to 0. Any write with select 3 clears it. A set in the same cycle wins over the clear.
- R7: `dac_stb` pulses for one cycle every P+1 cycles, where P is data bits [13:0] of a select-4 write. The reset value of P is 16383.
- R8: `dac_bclk` toggles every H+1 cycles, where H is data bits [3:0] of a select-5 write, giving a period of 2(H+1). When H is 0, `dac_bclk` stays low.
- R9: On each strobe the outputs take the next buffered sample. Beat bits [63:32] come first, then bits [31:0]. Within a 32-bit word, bits [31:16] go to the left channel and bits [15:0] to the right. If no sample is buffered, the previous sample is held. After reset both channels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the video-rate timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_status | output | 32 | Status: bit 31 and bit 0 full, bit 30 busy |
| mem_req | output | 1 | Beat read request |
| mem_addr | output | 24 | Byte address of the requested beat |
| mem_ack | input | 1 | Beat accepted; data valid |
| mem_rdata | input | 64 | Beat data |
| dac_bclk | output | 1 | Serial bit clock |
| dac_stb | output | 1 | Sample strobe |
| dac_left | output | 16 | Left sample |
| dac_right | output | 16 | Right sample |
| aud_irq | output | 1 | Queue-drain interrupt |

## Verification
Some results change in the same cycle as their cause:
- `mem_req` and `dac_stb` are combinational from registers.
- Busy and the full flag follow a register write one edge later.

The sample outputs change on the edge that sees the strobe. The bench therefore notes a strobe or an acknowledge seen shortly after a falling edge, and compares the samples at the next falling edge. It applies the strobe before the beat accepted in the same cycle, because the hardware does the same. The interrupt is checked in the same sampled cycle in which the full flag is seen to fall. Divider periods are taken from the third edge after a rate write, so that a counter left over from the old rate does not skew the measurement.

// File: rtl/ai_pkg.sv
package ai_pkg;
  typedef enum logic [2:0] {
    SEL_ADDR = 3'd0,
    SEL_LEN  = 3'd1,
    SEL_CTRL = 3'd2,
    SEL_STAT = 3'd3,
    SEL_DPER = 3'd4,
    SEL_HALF = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/ai_regq.sv
module ai_regq
  import ai_pkg::*;
#(
  parameter int AW = 24,
  parameter int LW = 18,
  parameter int DW = 14,
  parameter int HW = 4,
  localparam int BW = LW - 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [31:0]   wdata,
  input  logic          pop,
  output logic          en,
  output logic [DW-1:0] dper,
  output logic [HW-1:0] hp,
  output logic          head_valid,
  output logic          second_valid,
  output logic [AW-1:0] head_addr,
  output logic [BW-1:0] head_beats,
  output logic          full,
  output logic          irq
);
  logic [AW-1:0] addr_q, addr_d;
  logic          en_q, en_d, irq_q, irq_d;
  logic [DW-1:0] dper_q, dper_d;
  logic [HW-1:0] hp_q, hp_d;
  logic [AW-1:0] qa_q [2];
  logic [AW-1:0] qa_d [2];
  logic [BW-1:0] qb_q [2];
  logic [BW-1:0] qb_d [2];
  logic [1:0]    cnt_q, cnt_d;
  logic [BW-1:0] units;
  logic          push;

  always_comb begin
    addr_d = addr_q;
    en_d   = en_q;
    dper_d = dper_q;
    hp_d   = hp_q;
    units  = wdata[LW-1:3];
    push   = we && (sel == SEL_LEN) && (cnt_q != 2'd2) && (units != '0);
    if (we) begin
      case (sel)
        SEL_ADDR: addr_d = {wdata[AW-1:3], 3'b000};
        SEL_CTRL: en_d   = wdata[0];
        SEL_DPER: dper_d = wdata[DW-1:0];
        SEL_HALF: hp_d   = wdata[HW-1:0];
        default: ;
      endcase
    end
    qa_d  = qa_q;
    qb_d  = qb_q;
    cnt_d = cnt_q;
    if (pop) begin
      qa_d[0] = qa_q[1];
      qb_d[0] = qb_q[1];
      cnt_d   = cnt_q - 2'd1;
    end
    if (push) begin
      qa_d[cnt_d[0]] = addr_q;
      qb_d[cnt_d[0]] = units;
      cnt_d          = cnt_d + 2'd1;
    end
    irq_d = irq_q;
    if (we && (sel == SEL_STAT)) irq_d = 1'b0;
    if ((cnt_q == 2'd2) && (cnt_d != 2'd2)) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      en_q   <= 1'b0;
      dper_q <= '1;
      hp_q   <= '0;
      irq_q  <= 1'b0;
      cnt_q  <= '0;
      qa_q[0] <= '0;
      qa_q[1] <= '0;
      qb_q[0] <= '0;
      qb_q[1] <= '0;
    end else begin
      addr_q <= addr_d;
      en_q   <= en_d;
      dper_q <= dper_d;
      hp_q   <= hp_d;
      irq_q  <= irq_d;
      cnt_q  <= cnt_d;
      qa_q   <= qa_d;
      qb_q   <= qb_d;
    end
  end

  assign en           = en_q;
  assign dper         = dper_q;
  assign hp           = hp_q;
  assign head_valid   = (cnt_q != 2'd0);
  assign second_valid = (cnt_q == 2'd2);
  assign head_addr    = qa_q[0];
  assign head_beats   = qb_q[0];
  assign full         = (cnt_q == 2'd2);
  assign irq          = irq_q;
endmodule

// File: rtl/ai_fetch.sv
module ai_fetch #(
  parameter int AW = 24,
  parameter int BW = 15,
  parameter int SW = 16,
  localparam int DBW = 4 * SW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           head_valid,
  input  logic           second_valid,
  input  logic [AW-1:0]  head_addr,
  input  logic [BW-1:0]  head_beats,
  input  logic           stb,
  input  logic           mem_ack,
  input  logic [DBW-1:0] mem_data,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  output logic           pop,
  output logic           busy,
  output logic [SW-1:0]  left,
  output logic [SW-1:0]  right
);
  logic [BW-1:0]   idx_q, idx_d;
  logic [DBW-1:0]  buf_q, buf_d;
  logic [1:0]      scnt_q, scnt_d;
  logic [2*SW-1:0] smp_q, smp_d;
  logic            busy_q, busy_d;
  logic            take, last;

  always_comb begin
    mem_req  = en && head_valid && (scnt_q == 2'd0);
    mem_addr = head_addr + AW'({idx_q, 3'b000});
    take     = mem_req && mem_ack;
    last     = (idx_q == head_beats - 1'b1);
    pop      = take && last;
    idx_d    = idx_q;
    if (pop)       idx_d = '0;
    else if (take) idx_d = idx_q + 1'b1;
    buf_d  = buf_q;
    scnt_d = scnt_q;
    smp_d  = smp_q;
    if (stb && (scnt_q != 2'd0)) begin
      smp_d  = (scnt_q == 2'd2) ? buf_q[DBW-1:2*SW] : buf_q[2*SW-1:0];
      scnt_d = scnt_q - 2'd1;
    end
    if (take) begin
      buf_d  = mem_data;
      scnt_d = 2'd2;
    end
    busy_d = busy_q;
    if (pop)          busy_d = second_valid;
    else if (mem_req) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      buf_q  <= '0;
      scnt_q <= '0;
      smp_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      buf_q  <= buf_d;
      scnt_q <= scnt_d;
      smp_q  <= smp_d;
      busy_q <= busy_d;
    end
  end

  assign busy  = busy_q | mem_req;
  assign left  = smp_q[2*SW-1:SW];
  assign right = smp_q[SW-1:0];
endmodule

// File: rtl/ai_clkgen.sv
module ai_clkgen #(
  parameter int DW = 14,
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] dper,
  input  logic [HW-1:0] hp,
  output logic          stb,
  output logic          bclk
);
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic [HW-1:0] bcnt_q, bcnt_d;
  logic          bclk_q, bclk_d;

  always_comb begin
    stb    = (dcnt_q >= dper);
    dcnt_d = stb ? '0 : dcnt_q + 1'b1;
    if (hp == '0) begin
      bcnt_d = '0;
      bclk_d = 1'b0;
    end else if (bcnt_q >= hp) begin
      bcnt_d = '0;
      bclk_d = ~bclk_q;
    end else begin
      bcnt_d = bcnt_q + 1'b1;
      bclk_d = bclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      bcnt_q <= '0;
      bclk_q <= 1'b0;
    end else begin
      dcnt_q <= dcnt_d;
      bcnt_q <= bcnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk = bclk_q;
endmodule

// File: rtl/audio_dma_dac.sv
module audio_dma_dac #(
  parameter int AW = 24,
  parameter int LW = 18,
  parameter int DW = 14,
  parameter int HW = 4,
  parameter int SW = 16,
  localparam int BW  = LW - 3,
  localparam int DBW = 4 * SW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [2:0]     reg_sel,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_status,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_ack,
  input  logic [DBW-1:0] mem_rdata,
  output logic           dac_bclk,
  output logic           dac_stb,
  output logic [SW-1:0]  dac_left,
  output logic [SW-1:0]  dac_right,
  output logic           aud_irq
);
  logic          en_q, head_valid, second_valid, full, pop, busy;
  logic [DW-1:0] dper_q;
  logic [HW-1:0] hp_q;
  logic [AW-1:0] head_addr;
  logic [BW-1:0] head_beats;

  ai_regq #(.AW(AW), .LW(LW), .DW(DW), .HW(HW)) u_regq (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .pop(pop), .en(en_q), .dper(dper_q), .hp(hp_q), .head_valid(head_valid),
    .second_valid(second_valid), .head_addr(head_addr), .head_beats(head_beats),
    .full(full), .irq(aud_irq)
  );

  ai_fetch #(.AW(AW), .BW(BW), .SW(SW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .en(en_q), .head_valid(head_valid),
    .second_valid(second_valid), .head_addr(head_addr), .head_beats(head_beats),
    .stb(dac_stb), .mem_ack(mem_ack), .mem_data(mem_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .pop(pop), .busy(busy), .left(dac_left), .right(dac_right)
  );

  ai_clkgen #(.DW(DW), .HW(HW)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .dper(dper_q), .hp(hp_q), .stb(dac_stb), .bclk(dac_bclk)
  );

  assign reg_status = {full, busy, 29'd0, full};
endmodule

// File: rtl/ai_chk.sv
module ai_chk #(
  parameter int AW = 24,
  parameter int HW = 4,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          en_q,
  input logic [HW-1:0] hp_q,
  input logic [31:0]   reg_status,
  input logic          aud_irq,
  input logic          dac_bclk,
  input logic          dac_stb,
  input logic [SW-1:0] dac_left,
  input logic [SW-1:0] dac_right
);
  AST_ALIGNED_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[2:0] == 3'b000)); // R1
  AST_FETCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> en_q); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && en_q) |=> mem_req); // R5
  AST_BUSY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> reg_status[30]); // R5
  AST_IRQ_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_status[31]) |-> aud_irq); // R6
  AST_BCLK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_q == '0) |=> !dac_bclk); // R8
  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_stb |=> ($stable(dac_left) && $stable(dac_right))); // R9
endmodule

bind audio_dma_dac ai_chk #(.AW(AW), .HW(HW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .en_q(en_q), .hp_q(hp_q), .reg_status(reg_status),
  .aud_irq(aud_irq), .dac_bclk(dac_bclk), .dac_stb(dac_stb),
  .dac_left(dac_left), .dac_right(dac_right)
);

// File: tb/audio_dma_dac_tb.sv
module audio_dma_dac_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_status;
  logic        mem_req, mem_ack;
  logic [23:0] mem_addr;
  logic [63:0] mem_rdata;
  logic        dac_bclk, dac_stb, aud_irq;
  logic [15:0] dac_left, dac_right;

  int checks = 0, fails = 0, cyc = 0;
  logic [23:0] exp_a [0:511];
  logic [23:0] log_a [0:511];
  int exp_n = 0, log_n = 0, cmp_from = 0;
  logic [31:0] sf [0:1023];
  int sw = 0, sr = 0;
  logic [31:0] exp_smp = '0;
  bit pend = 0, prev_full = 0, en_tb = 0;
  int mdly = 0;

  always #10 clk = ~clk;

  audio_dma_dac u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_status(reg_status), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dac_bclk(dac_bclk), .dac_stb(dac_stb), .dac_left(dac_left),
    .dac_right(dac_right), .aud_irq(aud_irq)
  );

  function automatic logic [63:0] mdata(input logic [23:0] a);
    return {a ^ 24'h5A5A5A, 8'h3C, ~a, 8'hC3};
  endfunction

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic push(input logic [23:0] a, input int units, input logic [2:0] junk);
    wr(3'd0, {8'd0, a});
    wr(3'd1, (units << 3) | 32'(junk));
    for (int i = 0; i < units; i++) begin
      exp_a[exp_n] = {a[23:3], 3'b000} + 24'(8 * i);
      exp_n++;
    end
  endtask

  task automatic drain_and_compare();
    int t = 0;
    while (log_n < exp_n && t < 40000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(!reg_status[30], "R5 busy clear after drain", 64'(reg_status[30]), 0);
    for (int i = cmp_from; i < exp_n; i++)
      chk(log_a[i] == exp_a[i], "R1 fetch address", 64'(log_a[i]), 64'(exp_a[i]));
    cmp_from = exp_n;
  endtask

  task automatic measure_stb(output int per);
    int c;
    do @(negedge clk); while (!dac_stb);
    do @(negedge clk); while (!dac_stb);
    c = 0;
    do begin @(negedge clk); c++; end while (!dac_stb);
    per = c;
  endtask

  task automatic measure_bclk(output int per);
    int c;
    bit p;
    for (int k = 0; k < 3; k++) begin
      c = 0;
      p = dac_bclk;
      do begin p = dac_bclk; @(negedge clk); c++; end while (!(dac_bclk && !p) && c < 200);
    end
    per = c;
  endtask

  // memory model
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; mdly = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0; mdly = $urandom % 3;
    end else if (mem_req) begin
      if (mdly == 0) begin mem_ack = 1'b1; mem_rdata = mdata(mem_addr); end
      else mdly--;
    end
  end

  // monitor
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (pend) begin
        chk({dac_left, dac_right} == exp_smp, "R9 sample", 64'({dac_left, dac_right}), 64'(exp_smp));
        pend = 0;
      end
      if (dac_stb) begin
        if (sr != sw) begin exp_smp = sf[sr % 1024]; sr++; end
        pend = 1;
      end
      if (mem_req && mem_ack) begin
        log_a[log_n % 512] = mem_addr; log_n++;
        sf[sw % 1024] = mem_rdata[63:32]; sf[(sw + 1) % 1024] = mem_rdata[31:0]; sw += 2;
      end
      if (mem_req) begin
        chk(en_tb, "R4 request while disabled", 64'(mem_req), 0);
        chk(reg_status[30], "R5 busy during request", 64'(reg_status[30]), 1);
      end
      if (prev_full && !reg_status[31]) chk(aud_irq, "R6 irq on drain", 64'(aud_irq), 1);
      prev_full = reg_status[31];
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int per, hi, hp, dp, n, pre;
    void'($urandom(32'd4242));
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0; mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_status == 32'd0, "R3 reset status", 64'(reg_status), 0);
    chk(!aud_irq, "R6 reset irq", 64'(aud_irq), 0);
    chk(!mem_req, "R4 reset request", 64'(mem_req), 0);
    chk(!dac_bclk, "R8 reset bclk", 64'(dac_bclk), 0);
    chk({dac_left, dac_right} == 32'd0, "R9 reset sample", 64'({dac_left, dac_right}), 0);

    wr(3'd4, 32'd131);
    wr(3'd5, 32'd1);
    // directed: two entries with unaligned address and junk length bits
    push(24'($urandom) | 24'h5, 1 + $urandom % 4, 3'b110);
    chk(!reg_status[31], "R3 one entry not full", 64'(reg_status), 0);
    push(24'($urandom) | 24'h3, 1 + $urandom % 4, 3'b111);
    chk(reg_status[31] && reg_status[0], "R3 full flag both bits", 64'(reg_status), 64'h80000001);
    chk(!aud_irq, "R6 no irq on fill", 64'(aud_irq), 0);
    // third push while full is dropped
    wr(3'd0, 32'h00ABC0);
    wr(3'd1, 32'd5 << 3);
    repeat (20) @(negedge clk);
    chk(!mem_req, "R4 no request while disabled", 64'(mem_req), 0);
    measure_stb(per);
    chk(per == 132, "R7 strobe period", 64'(per), 132);
    measure_bclk(per);
    chk(per == 4, "R8 bclk period", 64'(per), 4);

    en_tb = 1;
    wr(3'd2, 32'd1);
    drain_and_compare();
    chk(aud_irq, "R6 irq held after drain", 64'(aud_irq), 1);
    wr(3'd3, 32'd0);
    chk(!aud_irq, "R6 status write clears", 64'(aud_irq), 0);
    repeat (600) @(negedge clk);
    chk(log_n == exp_n, "R3 dropped push fetched nothing", 64'(log_n), 64'(exp_n));

    // zero-unit length queues nothing
    pre = log_n;
    wr(3'd0, 32'h000100);
    wr(3'd1, 32'd7);
    repeat (20) @(negedge clk);
    chk(log_n == pre && reg_status == 32'd0, "R2 zero length ignored", 64'(reg_status), 0);

    // bit clock stopped
    wr(3'd5, 32'd0);
    hi = 0;
    repeat (40) begin @(negedge clk); if (dac_bclk) hi++; end
    chk(hi == 0, "R8 bclk stopped", 64'(hi), 0);

    // random rounds
    for (int r = 0; r < 4; r++) begin
      hp = 1 + $urandom % 3;
      dp = 66 * (hp + 1) - 1 + $urandom % 16;
      wr(3'd4, 32'(dp));
      wr(3'd5, 32'(hp));
      measure_stb(per);
      chk(per == dp + 1, "R7 strobe period random", 64'(per), 64'(dp + 1));
      measure_bclk(per);
      chk(per == 2 * (hp + 1), "R8 bclk period random", 64'(per), 64'(2 * (hp + 1)));
      n = 1 + $urandom % 2;
      for (int e = 0; e < n; e++) push(24'($urandom), 1 + $urandom % 4, 3'($urandom));
      drain_and_compare();
      wr(3'd3, 32'd0);
    end
    // let the buffer run dry so the hold case is seen
    repeat (2000) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule